// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This controller moves a group of registers to or from memory, one word per register. A single start strobe supplies a base register index, the base address, a 16-bit list of registers, the transfer direction, an addressing mode, a writeback request and a user-bank request. The block walks the list from the lowest set bit to the highest. For each register it raises a word request on a request/acknowledge memory port. For a store, the data comes from the register-file read port. For a load, the acknowledged read data goes out on the register-file write port.

The first address depends on the mode and on the number of registers in the list. Every later access sits 4 bytes above the previous one, so the lowest-numbered register always maps to the lowest address. When the last access has been acknowledged, a one-cycle done pulse appears. If writeback was requested, the final base address and the base index appear with that pulse. A load of register 15 raises a flag marking a change of program flow. A store can read the user-mode bank instead of the current bank.

Top module: `block_xfer_seq`

## Requirements
- R1: After reset, mem_req, done, wb_valid, rf_we and pc_load are all 0, and busy is 0.
- R2: A start in idle performs exactly one memory access for each set bit of the register list. The accesses run in ascending register index, so register 15 is always last. The register index appears on rf_rd_idx and rf_wr_idx.
- R3: The mode code sets the first access address and the final address, where n is the number of set bits: 2'b00 starts at base and ends at base+4n; 2'b01 starts at base+4 and ends at base+4n; 2'b10 starts at base-4n+4 and ends at base-4n; 2'b11 starts at base-4n and ends at base-4n. Each following access is at the previous address plus 4.
- R4: On a load (is_load=1), the cycle that acknowledges an access has rf_we=1, rf_wr_data equal to mem_rdata and mem_we=0.
- R5: On a store (is_load=0), mem_we=1 and mem_wdata equals rf_rd_data for the current register.
- R6: A request stays asserted with an unchanged address until mem_ack is seen.
- R7: done is a single-cycle pulse in the cycle after the last acknowledge. No request is active while done is high.
- R8: When wb_en was set at start, wb_valid comes with done, wb_idx equals the base index and wb_addr equals the final address from R3. When wb_en was clear, wb_valid stays 0.
- R9: An empty register list raises done in the cycle after start, with no memory access.
- R10: The acknowledged load of register 15 raises pc_load in that same cycle. pc_load stays 0 for every other register and for stores.
- R11: rf_rd_user is 1 during the accesses of a store started with user_bank=1. It is 0 at all other times, including loads started with user_bank=1.
- R12: mem_addr carries the low 26 bits of the byte address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| base_idx | input | 4 | Base register index |
| base_addr | input | 32 | Base register value |
| reg_list | input | 16 | Registers to transfer, bit i = register i |
| is_load | input | 1 | 1 = load, 0 = store |
| mode | input | 2 | Addressing mode code (see R3) |
| wb_en | input | 1 | Return final address for base writeback |
| user_bank | input | 1 | Store reads the user-mode bank |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 26 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ack | input | 1 | Memory acknowledge |
| rf_rd_idx | output | 4 | Register-file read index |
| rf_rd_user | output | 1 | Read from the user-mode bank |
| rf_rd_data | input | 32 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_wr_idx | output | 4 | Register-file write index |
| rf_wr_data | output | 32 | Register-file write data |
| pc_load | output | 1 | Register 15 loaded, program flow changes |
| done | output | 1 | Transfer complete pulse |
| wb_valid | output | 1 | Writeback value valid |
| wb_idx | output | 4 | Register to receive writeback |
| wb_addr | output | 32 | Final base address |

## Verification
The assertions assume that mem_ack is only raised while mem_req is high and lasts one cycle per access. They also assume that start is only pulsed while busy is low, and that the register-file read port answers combinationally in the same cycle. The bench memory model acknowledges only an active request, after a pseudo-random stall of zero to two cycles, and drops the acknowledge at the next falling edge. The driver waits for done before issuing the next start. Base addresses are word aligned, and one of them lies above the 26-bit range to show the truncation.

// File: rtl/block_xfer_seq.sv
module block_xfer_seq #(
  parameter int AW = 26,
  parameter int DW = 32,
  parameter int NREG = 16,
  localparam int IW = $clog2(NREG),
  localparam int CW = $clog2(NREG) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] base_idx,
  input  logic [DW-1:0] base_addr,
  input  logic [NREG-1:0] reg_list,
  input  logic          is_load,
  input  logic [1:0]    mode,
  input  logic          wb_en,
  input  logic          user_bank,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic [IW-1:0] rf_rd_idx,
  output logic          rf_rd_user,
  input  logic [DW-1:0] rf_rd_data,
  output logic          rf_we,
  output logic [IW-1:0] rf_wr_idx,
  output logic [DW-1:0] rf_wr_data,
  output logic          pc_load,
  output logic          done,
  output logic          wb_valid,
  output logic [IW-1:0] wb_idx,
  output logic [DW-1:0] wb_addr
);
  logic [NREG-1:0] remain;
  logic [DW-1:0]   addr, fin_r;
  logic            ld_r, ub_r, wb_r;
  logic [CW-1:0]   cnt;
  logic [IW-1:0]   cur;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) cnt = cnt + CW'(reg_list[i]);
  end

  always_comb begin
    cur = '0;
    for (int i = NREG - 1; i >= 0; i--) if (remain[i]) cur = IW'(i);
  end

  wire [DW-1:0] span  = DW'({cnt, 2'b00});
  wire [DW-1:0] lo    = base_addr - span;
  wire [DW-1:0] first = mode[1] ? (mode[0] ? lo : lo + DW'(4))
                                : (mode[0] ? base_addr + DW'(4) : base_addr);
  wire [DW-1:0] fin   = mode[1] ? lo : base_addr + span;
  wire          last  = (remain & (remain - NREG'(1))) == '0;
  wire          hit   = busy & mem_ack;

  assign mem_req    = busy;
  assign mem_we     = busy & ~ld_r;
  assign mem_addr   = addr[AW-1:0];
  assign mem_wdata  = rf_rd_data;
  assign rf_rd_idx  = cur;
  assign rf_rd_user = busy & ~ld_r & ub_r;
  assign rf_we      = hit & ld_r;
  assign rf_wr_idx  = cur;
  assign rf_wr_data = mem_rdata;
  assign pc_load    = rf_we & (cur == IW'(NREG - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; remain <= '0; addr <= '0; fin_r <= '0;
      ld_r <= 1'b0; ub_r <= 1'b0; wb_r <= 1'b0;
      done <= 1'b0; wb_valid <= 1'b0; wb_idx <= '0; wb_addr <= '0;
    end else begin
      done     <= 1'b0;
      wb_valid <= 1'b0;
      if (!busy && start) begin
        wb_idx <= base_idx;
        if (reg_list == '0) begin
          done     <= 1'b1;
          wb_valid <= wb_en;
          wb_addr  <= fin;
        end else begin
          busy   <= 1'b1;
          remain <= reg_list;
          addr   <= first;
          fin_r  <= fin;
          ld_r   <= is_load;
          ub_r   <= user_bank;
          wb_r   <= wb_en;
        end
      end else if (hit) begin
        remain <= remain & (remain - NREG'(1));
        addr   <= addr + DW'(4);
        if (last) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          wb_valid <= wb_r;
          wb_addr  <= fin_r;
        end
      end
    end
  end

  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req || mem_addr == $past(mem_addr) + AW'(4));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_no_req_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);
  a_r10_pc_last: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> done);
  a_r11_user_store: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd_user |-> mem_we);
  a_r8_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done);
endmodule

// File: tb/tb_block_xfer_seq.sv
module tb_block_xfer_seq;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic start = 0, is_load = 0, wb_en = 0, user_bank = 0, mem_ack = 0;
  logic [3:0] base_idx = 0;
  logic [31:0] base_addr = 0, mem_rdata = 0;
  logic [15:0] reg_list = 0;
  logic [1:0] mode = 0;
  logic busy, mem_req, mem_we, rf_rd_user, rf_we, pc_load, done, wb_valid;
  logic [25:0] mem_addr;
  logic [31:0] mem_wdata, rf_rd_data, rf_wr_data, wb_addr;
  logic [3:0] rf_rd_idx, rf_wr_idx, wb_idx;

  logic [31:0] rf [16];
  logic [31:0] ubk [16];
  assign rf_rd_data = rf_rd_user ? ubk[rf_rd_idx] : rf[rf_rd_idx];
  always @(posedge clk) if (rf_we) rf[rf_wr_idx] <= rf_wr_data;

  block_xfer_seq dut (.*);

  typedef struct { logic [25:0] a; logic we; logic [3:0] idx; logic [31:0] d; logic usr; } item_t;
  item_t q[$];
  int tests = 0, fails = 0, cyc = 0, ack_cyc = 0;
  logic [7:0] lfsr = 8'h5B;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] memval(logic [25:0] a);
    return {6'h15, a} ^ 32'h0F0F_0000;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp); end
  endtask

  initial begin : monitor
    int stall = 0;
    forever begin
      @(negedge clk);
      mem_ack = 0;
      if (mem_req) begin
        if (stall > 0) stall--;
        else begin
          item_t e;
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          stall = lfsr % 3;
          if (q.size() == 0) begin
            chk(0, "R2", "unexpected access", {6'd0, mem_addr}, 0);
          end else begin
            e = q.pop_front();
            chk(mem_addr == e.a, "R3/R12", "address", {6'd0, mem_addr}, {6'd0, e.a});
            chk(mem_we == e.we, "R4/R5", "direction", mem_we, e.we);
            chk(rf_rd_idx == e.idx, "R2", "register order", rf_rd_idx, e.idx);
            chk(rf_rd_user == e.usr, "R11", "user bank", rf_rd_user, e.usr);
            if (e.we) chk(mem_wdata == e.d, "R5", "store data", mem_wdata, e.d);
            else mem_rdata = memval(mem_addr);
            mem_ack = 1;
            ack_cyc = cyc;
            #1;
            chk(rf_we == !e.we, "R4", "rf_we", rf_we, !e.we);
            if (!e.we) chk(rf_wr_data == e.d && rf_wr_idx == e.idx, "R4", "load data", rf_wr_data, e.d);
            chk(pc_load == (!e.we && e.idx == 4'd15), "R10", "pc_load", pc_load, (!e.we && e.idx == 4'd15));
          end
        end
      end
    end
  end

  task automatic run(logic [15:0] lst, logic [31:0] base, logic [1:0] md,
                     logic ld, logic wb, logic ub, logic [3:0] bi);
    int n = 0, k = 0, g = 0;
    logic [31:0] a0, fin;
    for (int i = 0; i < 16; i++) n += lst[i];
    case (md)
      2'b00: begin a0 = base;           fin = base + 4*n; end
      2'b01: begin a0 = base + 4;       fin = base + 4*n; end
      2'b10: begin a0 = base - 4*n + 4; fin = base - 4*n; end
      default: begin a0 = base - 4*n;   fin = base - 4*n; end
    endcase
    for (int i = 0; i < 16; i++) if (lst[i]) begin
      item_t e;
      logic [31:0] ad = a0 + 4*k;
      e.a = ad[25:0]; e.we = !ld; e.idx = 4'(i); e.usr = !ld && ub;
      e.d = ld ? memval(ad[25:0]) : (ub ? ubk[i] : rf[i]);
      q.push_back(e);
      k++;
    end
    reg_list = lst; base_addr = base; mode = md; is_load = ld;
    wb_en = wb; user_bank = ub; base_idx = bi; start = 1;
    @(negedge clk); start = 0;
    while (!done && g < 500) begin @(negedge clk); g++; end
    if (n == 0) chk(g == 0 && !mem_req, "R9", "empty list done delay", g, 0);
    else chk(cyc == ack_cyc + 1, "R7", "done after last ack", cyc, ack_cyc + 1);
    chk(q.size() == 0, "R2", "accesses remaining", q.size(), 0);
    chk(wb_valid == wb, "R8", "wb_valid", wb_valid, wb);
    if (wb) chk(wb_addr == fin && wb_idx == bi, "R8", "wb_addr", wb_addr, fin);
    q.delete();
    @(negedge clk);
    chk(!done && !busy, "R7", "done pulse width", done, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      rf[i] = 32'h1000_0000 + 32'h111 * i;
      ubk[i] = 32'hC000_0000 + 32'h222 * i;
    end
    repeat (2) @(negedge clk);
    chk(!mem_req && !done && !wb_valid && !rf_we && !pc_load && !busy, "R1", "reset state",
        {mem_req, done, wb_valid, rf_we, pc_load, busy}, 0);
    rst_n = 1;
    @(negedge clk);
    run(16'h00A5, 32'h0000_0100, 2'b00, 1, 1, 0, 4'd2);
    run(16'h0F00, 32'h0000_2000, 2'b01, 0, 0, 0, 4'd3);
    run(16'h8003, 32'h0000_3000, 2'b10, 1, 1, 0, 4'd4);
    run(16'h1111, 32'h0000_4000, 2'b11, 0, 1, 1, 4'd5);
    run(16'h0000, 32'h0000_5000, 2'b11, 1, 1, 0, 4'd6);
    run(16'h0003, 32'h0400_0008, 2'b00, 0, 0, 0, 4'd7);
    run(16'h0240, 32'h0000_6000, 2'b01, 1, 0, 1, 4'd8);
    run(16'hFFFF, 32'h0001_0000, 2'b11, 0, 1, 0, 4'd9);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule